// File: doc/BRIEF.md
# PCI-to-DMA Window Address Translator

This block maps an address seen on the PCI side of a host bridge onto the 34-bit system DMA address space. It holds a small set of programmable windows. Each window has a base, a size mask and a translated base, all loaded through a simple write port. An incoming bus address is compared against the windows in a fixed priority order. The first enabled window that claims the address decides how it is rewritten.

A window works in one of two modes. In direct mode the block swaps the upper address bits for those of the translated base. The result is ready one cycle after the request is accepted, and a new request may be accepted in every cycle. In scatter-gather mode the block builds the address of a page-table entry and issues one 64-bit read on a memory port. It waits as long as the memory needs, then forms the final address from the page number in the returned entry and the page offset of the bus address. An address that no enabled window claims comes back unchanged, with the hit flag low.

Top module: `pci_dma_xlate`

## Requirements
- R1: After reset every window register is zero, so every address misses. Outputs rsp_valid and mem_req are low and req_ready is high.
- R2: A window claims an address when the address and the window base agree on every bit in 31:20 whose size-mask bit is 0. Size-mask bits outside 31:20, address bits outside 31:20 and base bits 19:2 take no part in the comparison.
- R3: Base bit 0 enables a window. A disabled window that would match is skipped, and the search goes on to the higher-numbered windows.
- R4: When several enabled windows claim an address, the lowest-numbered one decides.
- R5: Direct mode (base bit 1 = 0). Let M be the size-mask bits 31:20 with bits 19:0 set. The result takes the address bits where M is 1 and the translated-base bits where M is 0.
- R6: Scatter-gather mode (base bit 1 = 1). The block drives mem_req high for exactly one cycle, with mem_addr equal to the entry address, and holds mem_addr until the data returns. The entry address has the following bits:
  - bits 63:22: translated base bits 63:22
  - bits 21:10: address bits 31:20 where the size mask is 1, translated-base bits 21:10 where it is 0
  - bits 9:3: address bits 19:13
  - bits 2:0: zero
- R7: The scatter-gather result is the returned entry with bit 0 cleared, shifted left by 12, ORed with address bits 12:0.
- R8: Every translated result is cut to 34 bits, so rsp_addr bits 63:34 are zero when rsp_hit is 1. A miss returns all 64 address bits unchanged, with rsp_hit low.
- R9: req_ready is low from the acceptance of a scatter-gather request until its result is delivered. A direct or missing request gives its result in the cycle after acceptance, and back-to-back requests are accepted on consecutive cycles.
- R10: mem_rvalid is ignored except while the block waits for read data, which begins in the cycle after the mem_req cycle.
- R11: rsp_valid is a one-cycle pulse for each accepted request. For a scatter-gather request it comes in the cycle after mem_rvalid is taken.
- R12: The cfg_field codes are 0 for window base, 1 for size mask and 2 for translated base. A write with code 3 changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_win | input | WIN_IDX_W | Window index of the write |
| cfg_field | input | 2 | Register within the window (0 base, 1 mask, 2 translated base) |
| cfg_wdata | input | 64 | Write data |
| req_valid | input | 1 | Bus address request valid |
| req_ready | output | 1 | Block can accept a request |
| req_addr | input | 64 | Bus address to translate |
| mem_req | output | 1 | One-cycle read strobe for a page-table entry |
| mem_addr | output | 64 | Page-table entry address |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 64 | Returned page-table entry |
| rsp_valid | output | 1 | Result pulse |
| rsp_hit | output | 1 | A window claimed the address |
| rsp_addr | output | 64 | Translated (or passed-through) address |

## Verification
The bench sweeps bus address bits 23:20 across several windows, at both the top and the bottom of each page. It uses both zero and nonzero high address bits. The sweep catches a design that compares bits outside the size field, or that drops the high bits of a miss or keeps them on a hit. The layout has a disabled window in front of a matching one, which catches a design that stops the search at a disabled match, and a reprogrammed layout with overlapping enabled windows, which catches a design with the wrong priority. Scatter-gather reads are answered after varying delays, and a false data strobe is sent during the request cycle. A design that takes data too early, forgets to stall req_ready, or computes the wrong entry or page address shows up as a wrong mem_addr, rsp_addr or latency.

// File: rtl/xlate_pkg.sv
package xlate_pkg;

  localparam int unsigned REG_W      = 64;
  // size field of the mask register and window compare field
  localparam logic [REG_W-1:0] SIZE_FIELD = 64'h0000_0000_FFF0_0000;
  localparam logic [REG_W-1:0] LOW_PASS   = 64'h0000_0000_000F_FFFF;
  localparam logic [REG_W-1:0] PTE_IDX    = 64'h0000_0000_000F_E000;
  localparam logic [REG_W-1:0] PTE_ALIGN  = 64'h0000_0000_0000_03FF;
  localparam logic [REG_W-1:0] PAGE_OFF   = 64'h0000_0000_0000_1FFF;
  localparam int unsigned PTE_SHIFT  = 10;
  localparam int unsigned PAGE_SHIFT = 12;

  typedef enum logic [1:0] {
    FLD_BASE  = 2'd0,
    FLD_MASK  = 2'd1,
    FLD_TBASE = 2'd2,
    FLD_NONE  = 2'd3
  } fld_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2
  } st_e;

  typedef struct packed {
    logic [REG_W-1:0] base;
    logic [REG_W-1:0] mask;
    logic [REG_W-1:0] tbase;
  } win_cfg_t;

endpackage

// File: rtl/xlate_win_regs.sv
module xlate_win_regs
  import xlate_pkg::*;
#(
  parameter int unsigned NWIN  = 4,
  parameter int unsigned IDX_W = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [IDX_W-1:0]     wr_idx,
  input  fld_e                 wr_fld,
  input  logic [REG_W-1:0]     wr_data,
  output win_cfg_t [NWIN-1:0]  cfg_o
);

  for (genvar g = 0; g < NWIN; g++) begin : g_win
    win_cfg_t cfg_q, cfg_d;
    logic     sel_en;

    assign sel_en = wr_en && (wr_idx == IDX_W'(g));

    always_comb begin
      cfg_d = cfg_q;
      case (wr_fld)
        FLD_BASE:  cfg_d.base  = wr_data;
        FLD_MASK:  cfg_d.mask  = wr_data;
        FLD_TBASE: cfg_d.tbase = wr_data;
        default:   cfg_d       = cfg_q;
      endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cfg_q <= '0;
      end else if (sel_en) begin
        cfg_q <= cfg_d;
      end
    end

    assign cfg_o[g] = cfg_q;
  end

  // R12
  none_field_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_fld == FLD_NONE) |=> $stable(cfg_o));

endmodule

// File: rtl/xlate_win_match.sv
module xlate_win_match
  import xlate_pkg::*;
#(
  parameter int unsigned NWIN = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  win_cfg_t [NWIN-1:0] cfg_i,
  input  logic [REG_W-1:0]    bus_addr,
  output logic [NWIN-1:0]     grant,
  output logic                any_hit,
  output win_cfg_t            sel_cfg
);

  logic [NWIN-1:0] claim;

  for (genvar g = 0; g < NWIN; g++) begin : g_cmp
    logic [REG_W-1:0] cmp_mask;
    logic             field_eq;
    assign cmp_mask = ~cfg_i[g].mask & SIZE_FIELD;
    assign field_eq = ((bus_addr ^ cfg_i[g].base) & cmp_mask) == '0;
    assign claim[g] = field_eq && cfg_i[g].base[0];
  end

  // lowest-numbered claimant wins
  assign grant   = claim & (~claim + NWIN'(1));
  assign any_hit = |claim;

  always_comb begin
    sel_cfg = '0;
    for (int i = 0; i < NWIN; i++) begin
      sel_cfg = sel_cfg | ({$bits(win_cfg_t){grant[i]}} & cfg_i[i]);
    end
  end

  // R4
  grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant) && (any_hit == (grant != '0)));

endmodule

// File: rtl/xlate_addr_calc.sv
module xlate_addr_calc
  import xlate_pkg::*;
#(
  parameter int unsigned DMA_AW = 34
) (
  input  win_cfg_t         win,
  input  logic [REG_W-1:0] bus_addr,
  input  logic [REG_W-1:0] pte_data,
  input  logic [REG_W-1:0] pg_bus_addr,
  output logic [REG_W-1:0] direct_addr,
  output logic [REG_W-1:0] pte_addr,
  output logic [REG_W-1:0] sg_addr
);

  localparam logic [REG_W-1:0] DMA_MASK = (REG_W'(1) << DMA_AW) - REG_W'(1);

  logic [REG_W-1:0] size_bits;
  logic [REG_W-1:0] pass_mask;
  logic [REG_W-1:0] tb_keep;
  logic [REG_W-1:0] idx_mask;
  logic [REG_W-1:0] page_num;

  assign size_bits = win.mask & SIZE_FIELD;

  // direct substitution
  assign pass_mask   = size_bits | LOW_PASS;
  assign direct_addr = ((win.tbase & ~pass_mask) | (bus_addr & pass_mask)) & DMA_MASK;

  // page-table entry address
  assign tb_keep  = ~((size_bits >> PTE_SHIFT) | PTE_ALIGN);
  assign idx_mask = size_bits | PTE_IDX;
  assign pte_addr = (win.tbase & tb_keep) | ((bus_addr & idx_mask) >> PTE_SHIFT);

  // final address from the returned entry
  assign page_num = pte_data & ~REG_W'(1);
  assign sg_addr  = ((page_num << PAGE_SHIFT) | (pg_bus_addr & PAGE_OFF)) & DMA_MASK;

endmodule

// File: rtl/pci_dma_xlate.sv
module pci_dma_xlate
  import xlate_pkg::*;
#(
  parameter int unsigned NWIN      = 4,
  parameter int unsigned DMA_AW    = 34,
  parameter int unsigned WIN_IDX_W = (NWIN > 1) ? $clog2(NWIN) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_we,
  input  logic [WIN_IDX_W-1:0] cfg_win,
  input  logic [1:0]           cfg_field,
  input  logic [63:0]          cfg_wdata,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic [63:0]          req_addr,
  output logic                 mem_req,
  output logic [63:0]          mem_addr,
  input  logic                 mem_rvalid,
  input  logic [63:0]          mem_rdata,
  output logic                 rsp_valid,
  output logic                 rsp_hit,
  output logic [63:0]          rsp_addr
);

  // reset: asynchronous assertion, synchronous release
  logic rst_meta_q, rst_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_q      <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_q      <= rst_meta_q;
    end
  end

  win_cfg_t [NWIN-1:0] win_cfg;
  logic [NWIN-1:0]     grant;
  logic                any_hit;
  win_cfg_t            sel_cfg;
  logic [REG_W-1:0]    direct_addr, pte_addr, sg_addr;

  xlate_win_regs #(.NWIN(NWIN), .IDX_W(WIN_IDX_W)) regs_i (
    .clk     (clk),
    .rst_n   (rst_q),
    .wr_en   (cfg_we),
    .wr_idx  (cfg_win),
    .wr_fld  (fld_e'(cfg_field)),
    .wr_data (cfg_wdata),
    .cfg_o   (win_cfg)
  );

  xlate_win_match #(.NWIN(NWIN)) match_i (
    .clk      (clk),
    .rst_n    (rst_q),
    .cfg_i    (win_cfg),
    .bus_addr (req_addr),
    .grant    (grant),
    .any_hit  (any_hit),
    .sel_cfg  (sel_cfg)
  );

  // state registers
  st_e              state_q, state_d;
  logic [REG_W-1:0] cap_bus_q, cap_bus_d;
  logic [REG_W-1:0] pte_q, pte_d;
  logic             rsp_valid_q, rsp_valid_d;
  logic             rsp_hit_q, rsp_hit_d;
  logic [REG_W-1:0] rsp_addr_q, rsp_addr_d;
  logic             accept;
  logic             sel_sg;

  xlate_addr_calc #(.DMA_AW(DMA_AW)) calc_i (
    .win         (sel_cfg),
    .bus_addr    (req_addr),
    .pte_data    (mem_rdata),
    .pg_bus_addr (cap_bus_q),
    .direct_addr (direct_addr),
    .pte_addr    (pte_addr),
    .sg_addr     (sg_addr)
  );

  assign sel_sg    = sel_cfg.base[1];
  assign req_ready = (state_q == ST_IDLE);
  assign accept    = req_valid && req_ready;

  always_comb begin
    state_d     = state_q;
    cap_bus_d   = cap_bus_q;
    pte_d       = pte_q;
    rsp_valid_d = 1'b0;
    rsp_hit_d   = rsp_hit_q;
    rsp_addr_d  = rsp_addr_q;
    case (state_q)
      ST_IDLE: begin
        if (accept) begin
          if (any_hit && sel_sg) begin
            state_d   = ST_ISSUE;
            cap_bus_d = req_addr;
            pte_d     = pte_addr;
          end else begin
            rsp_valid_d = 1'b1;
            rsp_hit_d   = any_hit;
            rsp_addr_d  = any_hit ? direct_addr : req_addr;
          end
        end
      end
      ST_ISSUE: state_d = ST_WAIT;
      ST_WAIT: begin
        if (mem_rvalid) begin
          state_d     = ST_IDLE;
          rsp_valid_d = 1'b1;
          rsp_hit_d   = 1'b1;
          rsp_addr_d  = sg_addr;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      state_q     <= ST_IDLE;
      cap_bus_q   <= '0;
      pte_q       <= '0;
      rsp_valid_q <= 1'b0;
      rsp_hit_q   <= 1'b0;
      rsp_addr_q  <= '0;
    end else begin
      state_q     <= state_d;
      rsp_valid_q <= rsp_valid_d;
      if (accept) begin
        cap_bus_q <= cap_bus_d;
        pte_q     <= pte_d;
      end
      if (rsp_valid_d) begin
        rsp_hit_q  <= rsp_hit_d;
        rsp_addr_q <= rsp_addr_d;
      end
    end
  end

  assign mem_req   = (state_q == ST_ISSUE);
  assign mem_addr  = pte_q;
  assign rsp_valid = rsp_valid_q;
  assign rsp_hit   = rsp_hit_q;
  assign rsp_addr  = rsp_addr_q;

  // R9
  sg_stall_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (accept && any_hit && sel_sg) |=> (mem_req && !req_ready));

  // R6
  mem_pulse_chk: assert property (@(posedge clk) disable iff (!rst_q)
    mem_req |=> !mem_req);

  // R6
  mem_addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (state_q == ST_WAIT) |-> $stable(mem_addr));

  // R11
  rsp_after_data_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (state_q == ST_WAIT && mem_rvalid) |=> (rsp_valid && rsp_hit && req_ready));

  // R10
  stray_rvalid_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (state_q != ST_WAIT && !accept) |=> !rsp_valid);

  // R8
  xlate_width_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (rsp_valid && rsp_hit) |-> ((rsp_addr >> DMA_AW) == '0));

endmodule

// File: tb/pci_dma_xlate_tb_top.sv
module pci_dma_xlate_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we;
  logic [1:0]  cfg_win;
  logic [1:0]  cfg_field;
  logic [63:0] cfg_wdata;
  logic        req_valid;
  logic        req_ready;
  logic [63:0] req_addr;
  logic        mem_req;
  logic [63:0] mem_addr;
  logic        mem_rvalid;
  logic [63:0] mem_rdata;
  logic        rsp_valid;
  logic        rsp_hit;
  logic [63:0] rsp_addr;

  int n_chk = 0;
  int n_err = 0;
  int n_txn = 0;

  logic [63:0] m_base [4];
  logic [63:0] m_mask [4];
  logic [63:0] m_tb   [4];

  always #2 clk = ~clk;

  pci_dma_xlate dut_i (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_win(cfg_win), .cfg_field(cfg_field), .cfg_wdata(cfg_wdata),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_addr(rsp_addr)
  );

  task automatic chk(input logic ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  function automatic logic [63:0] pte_value(input logic [63:0] a);
    return {a[31:0] ^ 32'hA5C3_0F69, a[31:0] * 32'h0000_9E37 + 32'd1};
  endfunction

  // reference built from the requirement text
  task automatic model(input logic [63:0] a, output logic hit, output logic sg, output logic [63:0] val);
    logic [11:0] sz;
    logic [63:0] t;
    hit = 1'b0; sg = 1'b0; val = a;
    for (int w = 0; w < 4; w++) begin
      sz = m_mask[w][31:20];
      t  = m_tb[w];
      if (!hit && m_base[w][0] && (((a[31:20] ^ m_base[w][31:20]) & ~sz) == 12'h000)) begin
        hit = 1'b1;
        sg  = m_base[w][1];
        if (sg) val = {t[63:22], (t[21:10] & ~sz) | (a[31:20] & sz), a[19:13], 3'b000};
        else    val = {30'd0, t[33:32], (a[31:20] & sz) | (t[31:20] & ~sz), a[19:0]};
      end
    end
  endtask

  task automatic wr(input int w, input logic [1:0] f, input logic [63:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_win = 2'(w); cfg_field = f; cfg_wdata = d;
    case (f)
      2'd0: m_base[w] = d;
      2'd1: m_mask[w] = d;
      2'd2: m_tb[w]   = d;
      default: ;
    endcase
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic xlate(input logic [63:0] a, input int delay, input logic junk);
    logic        e_hit, e_sg, seen;
    logic [63:0] e_val, e_res;
    int          cnt, cyc, exp_cyc;
    model(a, e_hit, e_sg, e_val);
    e_res   = e_sg ? {30'd0, pte_value(e_val)[21:1], a[12:0]} : e_val;
    exp_cyc = e_sg ? delay + 2 : 1;
    seen = 1'b0; cnt = 0;
    @(negedge clk);
    req_valid = 1'b1; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    cyc = 1;
    while (!rsp_valid && cyc < 40) begin
      mem_rvalid = 1'b0;
      if (mem_req) begin
        if (seen) chk(1'b0, "R6 second strobe", 64'd1, 64'd0);
        seen = 1'b1;
        chk(mem_addr == e_val, "R6 entry address", mem_addr, e_val);
        chk(!req_ready, "R9 ready low while fetching", {63'd0, req_ready}, 64'd0);
        cnt = delay;
        if (junk) begin mem_rvalid = 1'b1; mem_rdata = ~pte_value(e_val); end
      end else if (cnt > 0) begin
        cnt--;
        if (cnt == 0) begin mem_rvalid = 1'b1; mem_rdata = pte_value(mem_addr); end
      end
      @(negedge clk);
      cyc++;
    end
    mem_rvalid = 1'b0;
    chk(rsp_valid, "R11 result delivered", {63'd0, rsp_valid}, 64'd1);
    chk(seen == e_sg, "R6 fetch issued only for scatter-gather", {63'd0, seen}, {63'd0, e_sg});
    chk(cyc == exp_cyc, "R9 result latency", 64'(cyc), 64'(exp_cyc));
    chk(rsp_hit == e_hit, "R3 hit flag", {63'd0, rsp_hit}, {63'd0, e_hit});
    chk(rsp_addr == e_res, e_sg ? "R7 scatter-gather result" : (e_hit ? "R5 direct result" : "R8 passthrough"),
        rsp_addr, e_res);
    @(negedge clk);
    chk(!rsp_valid, "R11 single pulse", {63'd0, rsp_valid}, 64'd0);
    n_txn++;
  endtask

  task automatic sweep();
    logic [63:0] a;
    logic [19:0] lo [3];
    lo[0] = 20'h00000; lo[1] = 20'h5A5A5; lo[2] = 20'hFFFFF;
    for (int hi = 0; hi < 16; hi++)
      for (int l = 0; l < 3; l++)
        for (int top = 0; top < 2; top++) begin
          a = {(top != 0) ? 32'hDEAD_0001 : 32'h0, 8'h00, 4'(hi), lo[l]};
          xlate(a, 1 + (n_txn % 3), (n_txn % 5) == 0);
        end
  endtask

  initial begin
    #(4 * 200000);
    n_err++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cfg_we = 1'b0; cfg_win = '0; cfg_field = '0; cfg_wdata = '0;
    req_valid = 1'b0; req_addr = '0; mem_rvalid = 1'b0; mem_rdata = '0;
    for (int w = 0; w < 4; w++) begin m_base[w] = '0; m_mask[w] = '0; m_tb[w] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk(req_ready, "R1 ready after reset", {63'd0, req_ready}, 64'd1);
    chk(!rsp_valid && !mem_req, "R1 quiet outputs", {62'd0, rsp_valid, mem_req}, 64'd0);
    xlate(64'h0000_0000_0000_0000, 1, 1'b0);
    xlate(64'hFFFF_FFFF_FFFF_FFFF, 1, 1'b0);

    // R10 stray data strobe while idle
    @(negedge clk); mem_rvalid = 1'b1; mem_rdata = 64'h1234;
    @(negedge clk); chk(!rsp_valid, "R10 idle strobe ignored", {63'd0, rsp_valid}, 64'd0);
    @(negedge clk); chk(!rsp_valid, "R10 idle strobe ignored", {63'd0, rsp_valid}, 64'd0);
    mem_rvalid = 1'b0;

    // layout A: direct, scatter-gather, disabled, direct
    wr(0, 2'd0, 64'h0000_0000_0010_0001);
    wr(0, 2'd1, 64'h0);
    wr(0, 2'd2, 64'h0000_0002_ABC0_0000);
    wr(1, 2'd0, 64'h0000_0000_0040_0003);
    wr(1, 2'd1, 64'h0000_0000_0030_0000);
    wr(1, 2'd2, 64'h0000_0000_1234_5000);
    wr(2, 2'd0, 64'h0000_0000_0080_0000);
    wr(2, 2'd1, 64'h0000_0000_0070_0000);
    wr(2, 2'd2, 64'h0000_0001_1110_0000);
    wr(3, 2'd0, 64'h0000_0000_00C0_0001);
    wr(3, 2'd1, 64'h0000_0000_0030_0000);
    wr(3, 2'd2, 64'h0000_0003_F000_0000);
    // R12 field code 3 changes nothing
    wr(0, 2'd3, 64'h0);
    xlate(64'h0000_0000_0015_4321, 1, 1'b0);
    sweep();   // R2 R3 R5 R6 R7 R8

    // R9 back-to-back direct requests
    @(negedge clk);
    req_valid = 1'b1; req_addr = 64'h0000_0000_0011_1111;
    @(negedge clk);
    chk(rsp_valid && rsp_addr == 64'h2_ABC1_1111, "R9 first back-to-back", rsp_addr, 64'h2_ABC1_1111);
    req_addr = 64'h0000_0000_00D2_2222;
    @(negedge clk);
    req_valid = 1'b0;
    chk(rsp_valid && rsp_addr == 64'h3_F012_2222, "R9 second back-to-back", rsp_addr, 64'h3_F012_2222);
    @(negedge clk);

    // layout B: overlapping enabled windows and junk in unused bits (R4, R2)
    wr(2, 2'd0, 64'hFFFF_0000_008A_BC03);
    wr(0, 2'd1, 64'hFFFF_FFFF_000F_0F0F);
    wr(1, 2'd2, 64'h0000_00F0_7654_3000);
    wr(3, 2'd0, 64'h0000_0000_0000_0001);
    wr(3, 2'd1, 64'h0000_0000_00F0_0000);
    sweep();

    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

endmodule